// File: doc/BRIEF.md
# Double-Buffered Display Control Registers with Frame-Synchronous Commit

This block holds the control words of a display pixel pipeline in two copies. Software writes 32-bit words into a staging copy through a simple word-addressed bus. The pixel pipeline works from an active copy, and the active copy only changes at the start of a vertical blanking interval. Each transfer moves every register at once, so the pipeline never sees half of an update mid-frame.

Software asks for a transfer by setting a request bit in a control word at address 0. The request is carried out at the next blanking start, not at once. The bit reads back as 1 until the transfer has happened and then drops to 0, so software can poll it before it stages the next update.

A second control bit turns off automatic loading. While that bit is clear, the staged values move to the active copy at every blanking start, whether or not a request is pending. Normal reads return the staging copy. A separate debug read port returns the active copy.

Top module: `shadow_commit_bank`

## Requirements
- R1: After synchronous reset, every staging and active register is zero, and the control word reads 0: no request is pending and automatic loading is enabled.
- R2: A bus write to a data address k (1 to NUM_REGS) updates staging register k. It leaves the active copy unchanged until a transfer takes place.
- R3: The control word sits at address 0. Bit 0 is the load request and bit 1 is the autoload-disable flag. Bit 1 takes the written value. All other bits read as 0.
- R4: When autoload is disabled and no request is pending, a blanking start leaves every active register unchanged.
- R5: When a request is pending, a blanking start copies every staging register into the active copy in that same cycle, and the request bit reads 0 afterwards.
- R6: A pending request stays set across cycles without a blanking start, and writing 0 to bit 0 does not cancel it.
- R7: While autoload is enabled, every blanking start copies the staging copy into the active copy, even with no request pending.
- R8: A data write in the same cycle as a blanking start lands only in staging. The active copy receives the value staged before that cycle, and the new value moves across at the following transfer.
- R9: A control write that sets bit 0 in the same cycle as a blanking start leaves the request pending for the next blanking start.
- R10: The bus read port returns staging values and the debug port returns active values. Addresses above NUM_REGS read as 0 on both ports, and writes to them change nothing.
- R11: Both read ports are registered. Data for an address presented before a clock edge appears after that edge and reflects the state before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blanking |
| bus_we | input | 1 | Write strobe |
| bus_waddr | input | ADDR_W | Word address of the write |
| bus_wdata | input | DATA_W | Write data |
| bus_raddr | input | ADDR_W | Word address of the read |
| bus_rdata | output | DATA_W | Registered staging or control read data |
| dbg_raddr | input | ADDR_W | Word address of the debug read |
| dbg_rdata | output | DATA_W | Registered active-copy read data |

## Verification
The bench builds the block with NUM_REGS set to 6, which gives a 3-bit address. Every data register, the control word and exactly one out-of-range code (7) are then all reachable in a few cycles. Writes, blanking pulses and the two read ports are driven in the same cycles, so the races between a write and a transfer (R8, R9), and between a read and a write (R11), are exercised directly.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  // Control word location and field positions; software decodes these.
  localparam int CTRL_ADDR    = 0;
  localparam int LOAD_BIT     = 0;
  localparam int AUTO_OFF_BIT = 1;
  localparam int CTRL_BITS    = 2;
endpackage

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl
  import shadow_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vblank_start,
  input  logic                 ctrl_we,
  input  logic [CTRL_BITS-1:0] ctrl_bits,
  output logic                 load_pend,
  output logic                 auto_off,
  output logic                 copy_en
);

  logic set_req;
  assign set_req = ctrl_we && ctrl_bits[LOAD_BIT];
  assign copy_en = vblank_start && (load_pend || !auto_off);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_pend <= 1'b0;
      auto_off  <= 1'b0;
    end else begin
      if (ctrl_we) auto_off <= ctrl_bits[AUTO_OFF_BIT];
      if (set_req)           load_pend <= 1'b1;
      else if (vblank_start) load_pend <= 1'b0;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!load_pend && !auto_off));

  assert_load_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (load_pend && !vblank_start) |=> load_pend);

  assert_load_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (vblank_start && !set_req) |=> !load_pend);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (vblank_start && set_req) |=> load_pend);

endmodule

// File: rtl/shadow_reg_store.sv
module shadow_reg_store #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              copy_en,
  input  logic [IDX_W-1:0]  stg_idx,
  input  logic [IDX_W-1:0]  act_idx,
  output logic [DATA_W-1:0] stg_val,
  output logic [DATA_W-1:0] act_val
);

  logic [DATA_W-1:0] stg [NUM_REGS];
  logic [DATA_W-1:0] act [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[g] <= '0;
        act[g] <= '0;
      end else begin
        if (wr_en && wr_idx == IDX_W'(g)) stg[g] <= wr_data;
        if (copy_en) act[g] <= stg[g];
      end
    end

    assert_active_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !copy_en |=> $stable(act[g]));
  end

  always_comb begin
    stg_val = '0;
    act_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (stg_idx == IDX_W'(i)) stg_val = stg[i];
      if (act_idx == IDX_W'(i)) act_val = act[i];
    end
  end

endmodule

// File: rtl/shadow_commit_bank.sv
module shadow_commit_bank
  import shadow_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vblank_start,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ADDR_W-1:0] dbg_raddr,
  output logic [DATA_W-1:0] dbg_rdata
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_ADDR);

  function automatic logic in_data(input logic [ADDR_W-1:0] a);
    return (a != CTRL_A) && (a <= LAST_ADDR);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - 1'b1;
    return off[IDX_W-1:0];
  endfunction

  logic ctrl_we, data_we, load_pend, auto_off, copy_en;
  logic [DATA_W-1:0] stg_val, act_val, ctrl_word;

  assign ctrl_we = bus_we && (bus_waddr == CTRL_A);
  assign data_we = bus_we && in_data(bus_waddr);

  shadow_commit_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .vblank_start (vblank_start),
    .ctrl_we      (ctrl_we),
    .ctrl_bits    (bus_wdata[CTRL_BITS-1:0]),
    .load_pend    (load_pend),
    .auto_off     (auto_off),
    .copy_en      (copy_en)
  );

  shadow_reg_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (data_we),
    .wr_idx  (to_idx(bus_waddr)),
    .wr_data (bus_wdata),
    .copy_en (copy_en),
    .stg_idx (to_idx(bus_raddr)),
    .act_idx (to_idx(dbg_raddr)),
    .stg_val (stg_val),
    .act_val (act_val)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[LOAD_BIT]     = load_pend;
    ctrl_word[AUTO_OFF_BIT] = auto_off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      dbg_rdata <= '0;
    end else begin
      if (bus_raddr == CTRL_A)      bus_rdata <= ctrl_word;
      else if (in_data(bus_raddr))  bus_rdata <= stg_val;
      else                          bus_rdata <= '0;
      dbg_rdata <= in_data(dbg_raddr) ? act_val : '0;
    end
  end

  assert_ctrl_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_raddr) == CTRL_A && !$past(rst)) |-> (bus_rdata[DATA_W-1:CTRL_BITS] == '0));

endmodule

// File: tb/test_shadow_commit_bank.sv
`timescale 1ns/1ps
module test_shadow_commit_bank;
  localparam int N  = 6;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst;
  logic vb, we;
  logic [AW-1:0] waddr, raddr, daddr;
  logic [31:0] wdata, rdata, ddata;

  always #2.5 clk = ~clk;

  shadow_commit_bank #(.NUM_REGS(N), .DATA_W(32)) i_shadow_commit_bank (
    .clk(clk), .rst(rst), .vblank_start(vb), .bus_we(we), .bus_waddr(waddr),
    .bus_wdata(wdata), .bus_raddr(raddr), .bus_rdata(rdata),
    .dbg_raddr(daddr), .dbg_rdata(ddata)
  );

  typedef struct packed { logic [31:0] r; logic [31:0] d; } exp_t;
  exp_t  q_exp[$];
  string q_tag[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] stg_m [1:N];
  logic [31:0] act_m [1:N];
  bit load_m, aoff_m;

  function automatic logic [31:0] exp_rd(input int a);
    if (a == 0) return {30'b0, aoff_m, load_m};
    if (a <= N) return stg_m[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_dbg(input int a);
    if (a >= 1 && a <= N) return act_m[a];
    return 32'h0;
  endfunction

  // Monitor: pops one expected item per edge and compares both ports.
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      exp_t e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks += 2;
      if (rdata !== e.r) begin
        fails++;
        $display("FAIL %s bus read: got %h expected %h", t, rdata, e.r);
      end
      if (ddata !== e.d) begin
        fails++;
        $display("FAIL %s debug read: got %h expected %h", t, ddata, e.d);
      end
    end
  end

  // One bus cycle: optional write, optional blanking pulse, optional read check.
  task automatic step(input bit w, input int a, input logic [31:0] d, input bit v,
                      input int ra, input int da, input bit chk, input string tag);
    bit copy;
    @(negedge clk);
    we = w; waddr = AW'(a); wdata = d; vb = v;
    raddr = AW'(ra); daddr = AW'(da);
    if (chk) begin
      q_exp.push_back('{r: exp_rd(ra), d: exp_dbg(da)});
      q_tag.push_back(tag);
    end
    @(posedge clk);
    #1;
    copy = v && (load_m || !aoff_m);
    if (copy) for (int i = 1; i <= N; i++) act_m[i] = stg_m[i];
    if (w) begin
      if (a == 0) aoff_m = d[1];
      else if (a <= N) stg_m[a] = d;
    end
    if (w && a == 0 && d[0]) load_m = 1;
    else if (v) load_m = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input bit v);
    step(1, a, d, v, 0, 0, 0, "");
  endtask

  task automatic rd(input int a, input string tag);
    step(0, 0, 0, 0, a, a, 1, tag);
  endtask

  task automatic blank();
    step(0, 0, 0, 1, 0, 0, 0, "");
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i <= 7; i++) rd(i, tag);
  endtask

  initial begin
    for (int i = 1; i <= N; i++) begin stg_m[i] = 0; act_m[i] = 0; end
    load_m = 0; aoff_m = 0;
    rst = 1; we = 0; vb = 0; waddr = 0; wdata = 0; raddr = 0; daddr = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    read_all("R1 reset state");

    // R2, R10: staging fills, active stays zero
    for (int i = 1; i <= N; i++) wr(i, 32'hA000_0000 + i * 32'h111, 0);
    read_all("R2 staged not active");

    // R7: autoload copies without a request
    blank();
    read_all("R7 autoload copy");
    wr(4, 32'h4444_0001, 0);
    blank();
    rd(4, "R7 second autoload copy");

    // R4: autoload off, no request -> no copy
    wr(0, 32'h2, 0);
    wr(3, 32'h3333_BEEF, 0);
    blank();
    read_all("R4 no copy without request");

    // R6: request pending, writing 0 to bit0 does not cancel
    wr(0, 32'h3, 0);
    rd(0, "R6 request reads set");
    rd(0, "R6 request held");
    wr(0, 32'h2, 0);
    rd(0, "R6 zero write ignored");

    // R8 + R5: write in blanking cycle lands in staging only
    wr(2, 32'h2222_CAFE, 1);
    read_all("R5 R8 commit with coincident write");
    wr(0, 32'h3, 0);
    blank();
    rd(2, "R8 picked up next commit");

    // R9: request set during blanking stays pending
    wr(1, 32'h1111_F00D, 0);
    wr(0, 32'h3, 1);
    rd(0, "R9 request survives blanking");
    rd(1, "R9 no copy yet");
    blank();
    rd(1, "R9 copied on next blanking");
    rd(0, "R5 request cleared");

    // R10: out-of-range write ignored; R3: upper control bits read zero
    wr(7, 32'hDEAD_DEAD, 0);
    read_all("R10 out of range write ignored");
    wr(0, 32'hFFFF_FFFE, 0);
    rd(0, "R3 only autoload bit kept");
    wr(0, 32'hFFFF_FFF0, 0);
    rd(0, "R3 autoload re-enabled");

    // R11: read in the write cycle shows the old value
    step(1, 5, 32'h5555_0042, 0, 5, 5, 1, "R11 read before write");
    rd(5, "R11 read after write");
    blank();
    rd(5, "R7 autoload after re-enable");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule